// File: doc/BRIEF.md
# Fast-page-mode DRAM controller

This block is a synchronous controller placed between a simple host request port and an asynchronous fast-page-mode DRAM with a 72-bit data bus. The host holds `host_req` with an address, a direction flag and write data until the controller answers with a one-cycle `host_ack`. For a read, `host_rdata` carries the read word during that acknowledge cycle. On the DRAM side the controller drives the multiplexed row/column address, the RAS, CAS, WE and OE strobes, and the write data with its own output enable. Every DRAM timing limit is a parameter counted in whole clock cycles.

After reset the controller holds all strobes inactive for `T_INIT` cycles. It then runs `N_INIT_REF` CAS-before-RAS refresh cycles before it accepts any host request. Once running, it keeps a row open so that requests to the same row become page-mode CAS cycles. A request to another row closes the row and reopens it. A pending refresh or the maximum RAS-low time also closes the row. A free-running interval counter raises a refresh request every `T_REFI` cycles.

The state machine has these states: PWRUP (power-up pause), IDLE (row closed), CBR_SETUP (CAS low, RAS high), CBR_HOLD (both low), CBR_TAIL (RAS low, CAS high), ACT (row address, RAS low), COL (column address, CAS high), CASLO (CAS low), CASHI (CAS precharge), OPEN (row open, waiting) and PRECH (RAS precharge).

The transitions are:
- PWRUP→IDLE when the pause ends.
- IDLE→CBR_SETUP when initial refreshes remain or a refresh is pending; otherwise IDLE→ACT on a request.
- CBR_SETUP→CBR_HOLD→CBR_TAIL→PRECH→IDLE.
- ACT→COL→CASLO→CASHI→OPEN.
- OPEN→COL on a same-row request.
- OPEN→PRECH on a refresh, a row miss or the RAS age guard, once the minimum RAS-low time is met.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: For `T_INIT` clock cycles after reset release, ras_n, cas_n, we_n and oe_n stay high and dq_oe and host_ack stay low.
- R2: No RAS fall with CAS high (row activation) occurs before `N_INIT_REF` (8) CAS-before-RAS refreshes have been issued and `T_INIT` cycles have elapsed.
- R3: In a refresh cycle, CAS is low for at least `T_CSR` cycles before RAS falls, and both stay low together for at least `T_CHR` cycles. No address is needed for it.
- R4: After initialisation, the spacing between successive refresh RAS falls is at most `T_REFI` + 64 cycles.
- R5: RAS stays high for at least `T_RP` cycles before every fall. Every RAS-low period lasts at least max(`T_RAS`, `T_RC`−`T_RP`) cycles.
- R6: CAS falls no earlier than `T_RCD` cycles after RAS falls in an access. The DRAM address carries the row (low `ROW_W` bits) when RAS falls and the column (low `COL_W` bits) when CAS falls. The host address is {row, column}, with the column in the low `COL_W` bits.
- R7: A request to the row that is already open is served without a new RAS fall, unless a refresh intervenes.
- R8: A request to a different row closes the open row and activates the new row.
- R9: A write is an early write. WE is already low in the cycle before CAS falls, and OE stays high. dq_oe is high and the write data are stable for the whole CAS-low time, which lasts at least `T_DH` cycles.
- R10: A read holds OE low with dq_oe low. CAS stays low for at least `T_CAC` cycles, and RAS has been low for at least `T_RAC` cycles by the time CAS rises. `host_rdata` returns the last word written to that address.
- R11: No RAS-low period exceeds `T_RASP_MAX` cycles, even under a continuous stream of same-row requests.
- R12: While a refresh cycle runs, no host acknowledge is given. A refresh that falls due during a stream of requests is still issued.
- R13: Each request receives exactly one `host_ack`, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+COL_W | Word address {row, column} |
| host_wdata | input | DQ_W | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DQ_W | Read data, valid with host_ack |
| dram_a | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | DQ_W | Data towards the DRAM |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DQ_W | Data from the DRAM |

## Verification
The hardest situation to reach from the ports is a refresh that falls due, or a RAS age that reaches its limit, while the host keeps hitting the open row. The host would never release that row by itself. The bench shortens the power-up pause, the refresh interval and the RAS-low limit through parameters. It then issues a long run of back-to-back same-row reads, so that the age guard and the refresh priority both have to break into a live page burst. Constrained-random traffic over four rows mixes page hits, row misses and unwritten addresses between these directed phases.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_CBR_SETUP,
        ST_CBR_HOLD,
        ST_CBR_TAIL,
        ST_ACT,
        ST_COL,
        ST_CASLO,
        ST_CASHI,
        ST_OPEN,
        ST_PRECH
    } fpm_state_e;

    function automatic int unsigned cyc_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_timer.sv
// Down-counter holding the dwell time of the current state.
module fpm_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= W'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/fpm_ras_age.sv
// Counts cycles since RAS fell; cleared while RAS is high, saturates.
module fpm_ras_age #(
    parameter int unsigned W   = 16,
    parameter int unsigned MAX = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ras_low,
    output logic [W-1:0] age
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age <= '0;
        else if (!ras_low)       age <= '0;
        else if (age != W'(MAX)) age <= age + 1'b1;
    end
endmodule

// File: rtl/fpm_refresh_sched.sv
// Raises a refresh request every INTERVAL cycles; cleared when taken.
module fpm_refresh_sched #(
    parameter int unsigned INTERVAL = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic pend
);
    localparam int unsigned RW = $clog2(INTERVAL + 1);
    logic [RW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= RW'(INTERVAL - 1);
            pend <= 1'b0;
        end else begin
            cnt <= tick ? RW'(INTERVAL - 1) : cnt - 1'b1;
            if (tick)      pend <= 1'b1;
            else if (take) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int unsigned ROW_W      = 11,
    parameter int unsigned COL_W      = 10,
    parameter int unsigned DQ_W       = 72,
    parameter int unsigned T_INIT     = 125000,
    parameter int unsigned T_REFI     = 3900,
    parameter int unsigned N_INIT_REF = 8,
    parameter int unsigned T_RP       = 10,
    parameter int unsigned T_RAS      = 15,
    parameter int unsigned T_RC       = 28,
    parameter int unsigned T_RCD      = 5,
    parameter int unsigned T_CAS      = 4,
    parameter int unsigned T_CP       = 3,
    parameter int unsigned T_CAC      = 5,
    parameter int unsigned T_RAC      = 15,
    parameter int unsigned T_DH       = 4,
    parameter int unsigned T_CSR      = 3,
    parameter int unsigned T_CHR      = 3,
    parameter int unsigned T_RASP_MAX = 50000,
    localparam int unsigned AW        = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic                   host_wr,
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [DQ_W-1:0]        host_wdata,
    output logic                   host_ack,
    output logic [DQ_W-1:0]        host_rdata,
    output logic [AW-1:0]          dram_a,
    output logic                   ras_n,
    output logic                   cas_n,
    output logic                   we_n,
    output logic                   oe_n,
    output logic [DQ_W-1:0]        dq_out,
    output logic                   dq_oe,
    input  logic [DQ_W-1:0]        dq_in
);
    localparam int unsigned RAS_MIN = cyc_max(T_RAS, (T_RC > T_RP) ? T_RC - T_RP : 0);
    localparam int unsigned CASLO_N = cyc_max(T_CAS, cyc_max(T_CAC, T_DH));
    localparam int unsigned GUARD   = CASLO_N + T_CP + 3;
    localparam int unsigned TW      = $clog2(cyc_max(T_INIT, RAS_MIN + T_RP + CASLO_N + T_RCD + T_CSR + T_CHR + T_CP) + 1);
    localparam int unsigned AGE_W   = $clog2(T_RASP_MAX + 1);
    localparam int unsigned IW      = $clog2(N_INIT_REF + 1);

    fpm_state_e        st, nxt;
    logic              ld, tdone, take, ref_pend, latch_row, latch_col;
    logic [TW-1:0]     ldv;
    logic [AGE_W-1:0]  age;
    logic [IW-1:0]     init_left;
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic              cur_wr;
    logic [DQ_W-1:0]   cur_wd;
    logic              row_miss, age_guard, ras_min_ok, cas_end;

    fpm_timer #(.W(TW), .RST_VAL(T_INIT - 1)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ldv), .done(tdone)
    );

    fpm_ras_age #(.W(AGE_W), .MAX(T_RASP_MAX)) age_i (
        .clk(clk), .rst_n(rst_n), .ras_low(!ras_n), .age(age)
    );

    fpm_refresh_sched #(.INTERVAL(T_REFI)) ref_i (
        .clk(clk), .rst_n(rst_n), .take(take), .pend(ref_pend)
    );

    assign row_miss   = host_req && (host_addr[ROW_W+COL_W-1:COL_W] != cur_row);
    assign age_guard  = ({1'b0, age} + (AGE_W+1)'(GUARD)) >= (AGE_W+1)'(T_RASP_MAX);
    assign ras_min_ok = age >= AGE_W'(RAS_MIN - 1);
    assign cas_end    = tdone && (cur_wr || age >= AGE_W'(T_RAC - 1));

    // next state and timer loads
    always_comb begin
        nxt       = st;
        ld        = 1'b0;
        ldv       = '0;
        take      = 1'b0;
        latch_row = 1'b0;
        latch_col = 1'b0;
        unique case (st)
            ST_PWRUP: if (tdone) nxt = ST_IDLE;
            ST_IDLE: begin
                if (init_left != '0 || ref_pend) begin
                    nxt = ST_CBR_SETUP; ld = 1'b1; ldv = TW'(T_CSR - 1); take = 1'b1;
                end else if (host_req) begin
                    nxt = ST_ACT; ld = 1'b1; ldv = TW'(T_RCD - 1); latch_row = 1'b1;
                end
            end
            ST_CBR_SETUP: if (tdone) begin nxt = ST_CBR_HOLD; ld = 1'b1; ldv = TW'(T_CHR - 1); end
            ST_CBR_HOLD:  if (tdone) nxt = ST_CBR_TAIL;
            ST_CBR_TAIL:  if (ras_min_ok) begin nxt = ST_PRECH; ld = 1'b1; ldv = TW'(T_RP - 1); end
            ST_ACT:       if (tdone) begin nxt = ST_COL; latch_col = 1'b1; end
            ST_COL:       begin nxt = ST_CASLO; ld = 1'b1; ldv = TW'(CASLO_N - 1); end
            ST_CASLO:     if (cas_end) begin nxt = ST_CASHI; ld = 1'b1; ldv = TW'(T_CP - 1); end
            ST_CASHI:     if (tdone) nxt = ST_OPEN;
            ST_OPEN: begin
                if (ref_pend || age_guard || row_miss) begin
                    if (ras_min_ok) begin nxt = ST_PRECH; ld = 1'b1; ldv = TW'(T_RP - 1); end
                end else if (host_req) begin
                    nxt = ST_COL; latch_col = 1'b1;
                end
            end
            ST_PRECH:     if (tdone) nxt = ST_IDLE;
            default:      nxt = ST_PWRUP;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= ST_PWRUP;
            init_left  <= IW'(N_INIT_REF);
            cur_row    <= '0;
            cur_col    <= '0;
            cur_wr     <= 1'b0;
            cur_wd     <= '0;
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            st <= nxt;
            if (take && init_left != '0) init_left <= init_left - 1'b1;
            if (latch_row) cur_row <= host_addr[ROW_W+COL_W-1:COL_W];
            if (latch_col) begin
                cur_col <= host_addr[COL_W-1:0];
                cur_wr  <= host_wr;
                cur_wd  <= host_wdata;
            end
            host_ack <= (st == ST_CASLO) && (nxt == ST_CASHI);
            if (st == ST_CASLO && nxt == ST_CASHI && !cur_wr) host_rdata <= dq_in;
        end
    end

    // strobe decode
    always_comb begin
        ras_n  = !(st inside {ST_CBR_HOLD, ST_CBR_TAIL, ST_ACT, ST_COL, ST_CASLO, ST_CASHI, ST_OPEN});
        cas_n  = !(st inside {ST_CBR_SETUP, ST_CBR_HOLD, ST_CASLO});
        we_n   = !(cur_wr && (st inside {ST_COL, ST_CASLO}));
        oe_n   = !(!cur_wr && st == ST_CASLO);
        dq_oe  = cur_wr && (st inside {ST_COL, ST_CASLO});
        dq_out = cur_wd;
        dram_a = (st inside {ST_COL, ST_CASLO}) ? AW'(cur_col) : AW'(cur_row);
    end
endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk #(
    parameter int unsigned T_RP       = 10,
    parameter int unsigned T_CSR      = 3,
    parameter int unsigned T_RASP_MAX = 50000
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic host_ack
);
    int unsigned hi_cnt, lo_cnt, cas_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt     <= 0;
            lo_cnt     <= 0;
            cas_lo_cnt <= 0;
        end else begin
            hi_cnt     <= ras_n  ? hi_cnt + 1 : 0;
            lo_cnt     <= !ras_n ? lo_cnt + 1 : 0;
            cas_lo_cnt <= !cas_n ? cas_lo_cnt + 1 : 0;
        end
    end

    AST_CBR_CAS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(ras_n) && !cas_n) |-> cas_lo_cnt >= T_CSR); // R3
    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(ras_n)) |-> hi_cnt >= T_RP); // R5
    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> $past(!we_n)); // R9
    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && oe_n)); // R9
    AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!dq_oe && !cas_n && !ras_n)); // R10
    AST_RAS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (lo_cnt < T_RASP_MAX)); // R11
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R13
endmodule

bind fpm_dram_ctrl fpm_ctrl_chk #(
    .T_RP(T_RP), .T_CSR(T_CSR), .T_RASP_MAX(T_RASP_MAX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dq_oe(dq_oe), .host_ack(host_ack)
);

// File: tb/fpm_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb_top;
    localparam int unsigned ROW_W = 11, COL_W = 10, DQ_W = 72;
    localparam int unsigned T_INIT = 300, T_REFI = 600, N_INIT = 8;
    localparam int unsigned T_RP = 10, T_RAS = 15, T_RC = 28, T_RCD = 5;
    localparam int unsigned T_CAS = 4, T_CP = 3, T_CAC = 5, T_RAC = 15, T_DH = 4;
    localparam int unsigned T_CSR = 3, T_CHR = 3, T_RASP_MAX = 400;
    localparam int unsigned RAS_MIN = 18;
    localparam int unsigned WD_LIMIT = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_req = 1'b0, host_wr = 1'b0;
    logic [ROW_W+COL_W-1:0] host_addr = '0;
    logic [DQ_W-1:0] host_wdata = '0, host_rdata, dq_out, dq_in;
    logic host_ack, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [10:0] dram_a;

    always #2 clk = ~clk;

    fpm_dram_ctrl #(.T_INIT(T_INIT), .T_REFI(T_REFI), .T_RASP_MAX(T_RASP_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .dram_a(dram_a), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int unsigned n_chk = 0, n_fail = 0, cyc = 0;
    bit wd_hit = 1'b0;

    task automatic check(input string rq, input logic [DQ_W-1:0] act, input logic [DQ_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [DQ_W-1:0] pat(input int unsigned a);
        return {8'hA5, 64'(a) * 64'h9E3779B97F4A7C15};
    endfunction

    // DRAM model and protocol monitor
    logic [DQ_W-1:0] dmem [int unsigned];
    logic [DQ_W-1:0] ref_mem [int unsigned];
    logic [DQ_W-1:0] rd_word = '0, wr_word = '0;
    assign dq_in = (!ras_n && !cas_n && !oe_n) ? rd_word : '0;

    bit prev_ras = 1, prev_cas = 1, prev_we = 1, in_cbr = 0, is_wr = 0, wr_bad = 0;
    bit r1_bad = 0, first_act = 1, ack_in_cbr = 0, req_in_cbr = 0;
    int unsigned ras_hi = 0, ras_lo = 0, cas_lo = 0, both_lo = 0;
    int unsigned cbr_cnt = 0, act_cnt = 0, cbr_last = 0, cbr_with_req = 0;
    logic [ROW_W-1:0] mdl_row = '0;
    logic [COL_W-1:0] mdl_col = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cyc >= WD_LIMIT) wd_hit = 1'b1;
            if (cyc <= T_INIT && (!ras_n || !cas_n || !we_n || !oe_n || dq_oe || host_ack)) r1_bad = 1;
            if (!ras_n && prev_ras) begin
                check("R5 precharge", 72'(ras_hi >= T_RP), 72'(1));
                if (!cas_n) begin
                    check("R3 cas lead", 72'(cas_lo >= T_CSR), 72'(1));
                    if (cbr_cnt >= N_INIT)
                        check("R4 refresh spacing", 72'(cyc - cbr_last <= T_REFI + 64), 72'(1));
                    cbr_cnt++; cbr_last = cyc; in_cbr = 1; ack_in_cbr = 0; req_in_cbr = 0;
                end else begin
                    in_cbr = 0; act_cnt++; mdl_row = dram_a[ROW_W-1:0];
                    if (first_act) begin
                        first_act = 0;
                        check("R2 init before access", 72'(cbr_cnt >= N_INIT && cyc > T_INIT), 72'(1));
                    end
                end
            end
            if (!ras_n && in_cbr) begin
                if (host_ack) ack_in_cbr = 1;
                if (host_req) req_in_cbr = 1;
            end
            if (ras_n && !prev_ras) begin
                check("R5 ras low min", 72'(ras_lo >= RAS_MIN), 72'(1));
                check("R11 ras low max", 72'(ras_lo <= T_RASP_MAX), 72'(1));
                if (in_cbr) begin
                    check("R12 no ack in refresh", 72'(ack_in_cbr), 72'(0));
                    if (req_in_cbr) cbr_with_req++;
                end
            end
            if (!cas_n && prev_cas && !ras_n && !in_cbr) begin
                check("R6 ras to cas", 72'(ras_lo >= T_RCD), 72'(1));
                mdl_col = dram_a[COL_W-1:0];
                is_wr = !we_n; wr_bad = 0;
                if (is_wr) begin
                    check("R9 we before cas", 72'({prev_we, oe_n}), 72'(2'b01));
                    dmem[{mdl_row, mdl_col}] = dq_out; wr_word = dq_out;
                end else begin
                    rd_word = dmem.exists({mdl_row, mdl_col}) ? dmem[{mdl_row, mdl_col}] : pat({mdl_row, mdl_col});
                end
            end
            if (!cas_n && !ras_n && !in_cbr && is_wr && (!dq_oe || dq_out !== wr_word)) wr_bad = 1;
            if (!cas_n && !ras_n) both_lo++;
            if (cas_n && !prev_cas) begin
                if (in_cbr) check("R3 cas hold", 72'(both_lo >= T_CHR), 72'(1));
                else if (is_wr) check("R9 write data hold", 72'(!wr_bad && cas_lo >= T_DH), 72'(1));
                else check("R10 read strobe timing", 72'(cas_lo >= T_CAC && ras_lo >= T_RAC), 72'(1));
                both_lo = 0;
            end
            ras_hi = ras_n ? ras_hi + 1 : 0;
            ras_lo = !ras_n ? ras_lo + 1 : 0;
            cas_lo = !cas_n ? cas_lo + 1 : 0;
            prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n;
        end
    end

    task automatic access(input bit wr, input int unsigned a, input logic [DQ_W-1:0] d);
        logic [DQ_W-1:0] exp;
        if (wd_hit) return;
        exp = ref_mem.exists(a) ? ref_mem[a] : pat(a);
        @(negedge clk);
        host_req = 1; host_wr = wr; host_addr = (ROW_W+COL_W)'(a); host_wdata = d;
        @(negedge clk);
        while (!host_ack && !wd_hit) @(negedge clk);
        host_req = 0;
        if (wd_hit) return;
        if (wr) ref_mem[a] = d;
        else check("R10 read data", host_rdata, exp);
        @(negedge clk);
        check("R13 ack single cycle", 72'(host_ack), 72'(0));
    endtask

    function automatic int unsigned mk(input int unsigned row, input int unsigned col);
        return (row << COL_W) | (col & ((1 << COL_W) - 1));
    endfunction

    initial begin
        int unsigned a0, c0;
        void'($urandom(32'h5eed));
        repeat (5) @(negedge clk);
        rst_n = 1;
        access(1, mk(5, 1), 72'h11_2233_4455_6677_8899);
        check("R1 quiet power-up", 72'(r1_bad), 72'(0));
        a0 = act_cnt; c0 = cbr_cnt;
        access(1, mk(5, 2), 72'hFF_0000_1111_2222_3333);
        check("R7 page hit", 72'(act_cnt == a0 || cbr_cnt != c0), 72'(1));
        a0 = act_cnt; c0 = cbr_cnt;
        access(0, mk(9, 3), '0);
        check("R8 row miss reopens", 72'((act_cnt == a0 + 1 || cbr_cnt != c0) && mdl_row == 11'd9), 72'(1));
        access(0, mk(5, 1), '0);
        access(0, mk(5, 2), '0);
        for (int i = 0; i < 300; i++) begin
            int unsigned row = $urandom % 4, col = $urandom % 1024;
            access(1'($urandom % 2), mk(row, col), {$urandom, $urandom, 8'($urandom)});
        end
        for (int i = 0; i < 120; i++) access(0, mk(2, i % 16), '0);
        check("R12 refresh inside stream", 72'(cbr_with_req > 0), 72'(1));
        if (wd_hit) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, WD_LIMIT);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule